// File: doc/BRIEF.md
# Windowed Walsh Flicker Pattern Meter

The meter estimates how strongly a video stream carries each of four temporal flicker patterns. In every frame it looks at one short horizontal run of pixels on the first line after the frame start. The run moves one window to the right from one frame to the next. After a programmed number of frames, the samples taken over those frames cover a stretch of the line that is the frame count times the window width.

Each sampled luma value is added to, or subtracted from, four running sums. The sign comes from a Walsh sequence evaluated at the current frame index, and a selector picks which group of four sequences is used. When the last frame of a measurement ends, the four sums move into output score registers and a one-cycle completion strobe is raised. The sums then restart for the next measurement.

Top module: `flicker_walsh_meter`

## Requirements
- R1: After reset, every score output is zero and `done_o` is low. Both stay so until a measurement completes.
- R2: The window width is W = 2^(3 + `win_log_i`) pixels. Columns are counted over valid pixels only, and column 0 is the valid pixel that arrives with `line_start_i`. In frame k of a measurement, only columns k*W through (k+1)*W-1 are sampled.
- R3: Only the first line that starts at or after a frame start is sampled. The following inputs have no effect on the scores:
  - pixels outside the window;
  - cycles in which `pix_valid_i` is low;
  - pixels on any later line of the frame.
- R4: Score p (0..3) uses the Walsh index w = 4*`walsh_sel_i` + p. The sampled luma is subtracted when the parity of (w AND the five low bits of the frame index) is odd. Otherwise it is added.
- R5: A measurement spans `meas_frames_i` frames, and a value of 0 acts as 1. The frame index runs from 0 up to that count minus 1 and then returns to 0.
- R6: The first frame start after reset only opens frame 0. A later frame start that closes the last frame of a measurement has three effects:
  - the sums are loaded into `score_o`;
  - `done_o` is high for exactly the next cycle;
  - the sums restart from zero.
  `done_o` is low at every other time.
- R7: `score_o` holds its value in every cycle in which `done_o` is low.
- R8: `win_log_i`, `meas_frames_i` and `walsh_sel_i` are captured at the frame start that opens a measurement. A change during the measurement takes effect only at the next measurement.
- R9: A frame start may come in the same cycle as a line start. That line is then the sampled line of the new frame, and its first pixel counts as column 0 of the new frame (and of the new measurement).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_valid_i | input | 1 | Pixel present this cycle |
| line_start_i | input | 1 | First cycle of a line |
| frame_start_i | input | 1 | Frame start strobe |
| luma_i | input | 8 | Pixel luma, unsigned |
| win_log_i | input | 4 | Window size code, W = 2^(3+code) |
| meas_frames_i | input | 8 | Frames per measurement |
| walsh_sel_i | input | 3 | Walsh group selector |
| score_o | output | 4x32 | Scores, pattern p in bits [32p+31:32p], two's complement |
| done_o | output | 1 | One-cycle measurement-complete strobe |

## Verification
A wrong frame index or column count moves the window. The damage then shows only as wrong score values, and only at the completion strobe that ends the affected measurement, which can be many frames later. The bench therefore compares all four scores at every strobe over a sweep of every selector value, several window sizes and frame counts, both frame-start alignments, and configuration changes made mid-measurement. A wrong measurement-boundary state shows up sooner, as a missing, early or stretched `done_o` on the cycle after a frame start.

// File: rtl/fwm_pkg.sv
package fwm_pkg;
  localparam int unsigned WIN_BASE_LOG = 3;

  // 1 when the Walsh function w is negative at sequence position k
  function automatic logic walsh_neg(input logic [7:0] w, input logic [7:0] k);
    return ^(w & k);
  endfunction
endpackage

// File: rtl/fwm_frame_seq.sv
module fwm_frame_seq #(
  parameter int unsigned FCNT_W   = 8,
  parameter int unsigned LOG_W    = 4,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned FCNT_RST = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [LOG_W-1:0]  log_i,
  input  logic [FCNT_W-1:0] fcnt_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [FCNT_W-1:0] idx_o,
  output logic [LOG_W-1:0]  log_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              meas_end_o
);
  logic              started_q;
  logic [FCNT_W-1:0] idx_q, fcnt_q;
  logic [LOG_W-1:0]  log_q;
  logic [SEL_W-1:0]  sel_q;
  logic [FCNT_W:0]   idx_inc;
  logic              meas_start;

  always_comb begin
    idx_inc    = {1'b0, idx_q} + 1'b1;
    meas_end_o = started_q & frame_start_i & (idx_inc >= {1'b0, fcnt_q});
    meas_start = frame_start_i & (~started_q | meas_end_o);
    idx_o      = idx_q;
    if (frame_start_i) idx_o = meas_start ? '0 : idx_inc[FCNT_W-1:0];
    log_o      = meas_start ? log_i : log_q;
    sel_o      = meas_start ? sel_i : sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      idx_q     <= '0;
      fcnt_q    <= FCNT_W'(FCNT_RST);
      log_q     <= '0;
      sel_q     <= '0;
    end else if (frame_start_i) begin
      started_q <= 1'b1;
      idx_q     <= idx_o;
      if (meas_start) begin
        fcnt_q <= fcnt_i;
        log_q  <= log_i;
        sel_q  <= sel_i;
      end
    end
  end
endmodule

// File: rtl/fwm_window.sv
module fwm_window #(
  parameter int unsigned LOG_W  = 4,
  parameter int unsigned FCNT_W = 8,
  parameter int unsigned COL_W  = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  input  logic              line_start_i,
  input  logic              frame_start_i,
  input  logic [LOG_W-1:0]  log_i,
  input  logic [FCNT_W-1:0] idx_i,
  output logic              sample_o
);
  localparam int unsigned SH_W = LOG_W + 1;

  logic             armed_q, active_q, line_on, in_win;
  logic [COL_W-1:0] col_q, cur_col, col_inc;
  logic [SH_W-1:0]  sh;

  always_comb begin
    sh       = SH_W'(log_i) + SH_W'(fwm_pkg::WIN_BASE_LOG);
    cur_col  = line_start_i ? '0 : col_q;
    line_on  = line_start_i ? (armed_q | frame_start_i) : (active_q & ~frame_start_i);
    in_win   = (cur_col >> sh) == COL_W'(idx_i);
    sample_o = pix_valid_i & line_on & in_win;
    col_inc  = (&cur_col) ? cur_col : cur_col + 1'b1;  // saturate, never re-enter a window
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      col_q    <= '0;
    end else begin
      armed_q  <= line_start_i ? 1'b0 : (armed_q | frame_start_i);
      active_q <= line_on;
      col_q    <= pix_valid_i ? col_inc : cur_col;
    end
  end
endmodule

// File: rtl/fwm_accum.sv
module fwm_accum #(
  parameter int unsigned LUMA_W  = 8,
  parameter int unsigned SCORE_W = 32,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned N_PAT   = 4,
  parameter int unsigned IDX_W   = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           sample_i,
  input  logic [LUMA_W-1:0]              luma_i,
  input  logic [SEL_W-1:0]               sel_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic                           meas_end_i,
  output logic [N_PAT-1:0][SCORE_W-1:0]  score_o,
  output logic                           done_o
);
  localparam int unsigned PAT_W = (N_PAT > 1) ? $clog2(N_PAT) : 1;

  logic [SCORE_W-1:0] mag;
  assign mag = SCORE_W'(luma_i);

  for (genvar p = 0; p < N_PAT; p++) begin : g_pat
    localparam logic [PAT_W-1:0] PIDX = PAT_W'(p);
    logic [SCORE_W-1:0] acc_q, score_q, term;
    logic               neg;

    always_comb begin
      neg  = fwm_pkg::walsh_neg(8'({sel_i, PIDX}), 8'(idx_i));
      term = '0;
      if (sample_i) term = neg ? ('0 - mag) : mag;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q   <= '0;
        score_q <= '0;
      end else if (meas_end_i) begin
        score_q <= acc_q;
        acc_q   <= term;  // sample in the closing cycle belongs to the new run
      end else begin
        acc_q   <= acc_q + term;
      end
    end

    assign score_o[p] = score_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= meas_end_i;
  end
endmodule

// File: rtl/flicker_walsh_meter.sv
module flicker_walsh_meter #(
  parameter int unsigned LUMA_W  = 8,
  parameter int unsigned SCORE_W = 32,
  parameter int unsigned LOG_W   = 4,
  parameter int unsigned FCNT_W  = 8,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned N_PAT   = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          pix_valid_i,
  input  logic                          line_start_i,
  input  logic                          frame_start_i,
  input  logic [LUMA_W-1:0]             luma_i,
  input  logic [LOG_W-1:0]              win_log_i,
  input  logic [FCNT_W-1:0]             meas_frames_i,
  input  logic [SEL_W-1:0]              walsh_sel_i,
  output logic [N_PAT-1:0][SCORE_W-1:0] score_o,
  output logic                          done_o
);
  localparam int unsigned COL_W = FCNT_W + fwm_pkg::WIN_BASE_LOG + (1 << LOG_W) - 1;

  logic [FCNT_W-1:0] idx_eff;
  logic [LOG_W-1:0]  log_eff;
  logic [SEL_W-1:0]  sel_eff;
  logic              meas_end, sample;

  fwm_frame_seq #(.FCNT_W(FCNT_W), .LOG_W(LOG_W), .SEL_W(SEL_W), .FCNT_RST(8)) u_seq (
    .clk_i, .rst_ni, .frame_start_i,
    .log_i(win_log_i), .fcnt_i(meas_frames_i), .sel_i(walsh_sel_i),
    .idx_o(idx_eff), .log_o(log_eff), .sel_o(sel_eff), .meas_end_o(meas_end)
  );

  fwm_window #(.LOG_W(LOG_W), .FCNT_W(FCNT_W), .COL_W(COL_W)) u_win (
    .clk_i, .rst_ni, .pix_valid_i, .line_start_i, .frame_start_i,
    .log_i(log_eff), .idx_i(idx_eff), .sample_o(sample)
  );

  fwm_accum #(.LUMA_W(LUMA_W), .SCORE_W(SCORE_W), .SEL_W(SEL_W), .N_PAT(N_PAT),
              .IDX_W(FCNT_W)) u_acc (
    .clk_i, .rst_ni, .sample_i(sample), .luma_i, .sel_i(sel_eff), .idx_i(idx_eff),
    .meas_end_i(meas_end), .score_o, .done_o
  );
endmodule

// File: rtl/fwm_checker.sv
module fwm_checker #(
  parameter int unsigned SCORE_W = 32,
  parameter int unsigned N_PAT   = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          frame_start_i,
  input logic [N_PAT-1:0][SCORE_W-1:0] score_o,
  input logic                          done_o
);
  logic [1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         seen_q <= '0;
    else if (frame_start_i && seen_q != 2'd3) seen_q <= seen_q + 1'b1;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == 2'd0) |-> (score_o == '0 && !done_o)); // R1
  AST_NO_EARLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (seen_q >= 2'd2)); // R6
  AST_DONE_AFTER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(frame_start_i)); // R6
  AST_SCORE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(score_o)); // R7
  AST_SCORE_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(score_o)); // R7
endmodule

bind flicker_walsh_meter fwm_checker #(.SCORE_W(SCORE_W), .N_PAT(N_PAT)) u_fwm_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
  .score_o(score_o), .done_o(done_o)
);

// File: tb/flicker_walsh_meter_bench.sv
`timescale 1ns/1ps
module flicker_walsh_meter_bench;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pix_valid = 1'b0, line_start = 1'b0, frame_start = 1'b0;
  logic [7:0]       luma = '0;
  logic [3:0]       win_log = '0;
  logic [7:0]       meas_frames = 8'd8;
  logic [2:0]       walsh_sel = '0;
  logic [3:0][31:0] score;
  logic             done;

  always #2 clk = ~clk;

  flicker_walsh_meter u_flicker_walsh_meter (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pix_valid), .line_start_i(line_start),
    .frame_start_i(frame_start), .luma_i(luma), .win_log_i(win_log),
    .meas_frames_i(meas_frames), .walsh_sel_i(walsh_sel), .score_o(score), .done_o(done)
  );

  int          n_checks = 0, n_fail = 0;
  logic [31:0] acc[4], expv[4], last_sc[4];
  bit          pending = 0, started = 0;
  int          salt = 3;

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] expd);
    n_checks++;
    if (act !== expd) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expd);
    end
  endtask

  function automatic bit sign_neg(input int sel, input int p, input int k);
    int w = sel * 4 + p;
    return ($countones(w & (k % 32)) % 2) == 1;
  endfunction

  task automatic do_frame(input int k, input bit fs_ls, input int msel, input int mlog);
    int  w = 1 << (3 + mlog);
    int  lead = fs_ls ? 0 : 1;
    int  total = lead + 2 * 90 + 4;
    int  col = 0;
    bit  pulsed = 0;
    for (int c = 0; c < total; c++) begin
      @(negedge clk);
      if (c == 1) begin
        if (pending) begin
          check_eq("R6 done strobe at completion", 32'(done), 32'd1);
          for (int p = 0; p < 4; p++) begin
            check_eq($sformatf("R4 R2 R3 score%0d", p), score[p], expv[p]);
            last_sc[p] = expv[p];
          end
          pending = 0;
          pulsed  = 1;
        end else begin
          check_eq("R6 no strobe inside measurement", 32'(done), 32'd0);
        end
      end
      if (c == 2 && pulsed) check_eq("R6 strobe lasts one cycle", 32'(done), 32'd0);
      frame_start = (c == 0);
      line_start  = 1'b0;
      pix_valid   = 1'b0;
      luma        = '0;
      if (c >= lead && c < lead + 180) begin
        int line = (c - lead) / 90;
        int lc   = (c - lead) % 90;
        line_start = (lc == 0);
        if (lc == 0) col = 0;
        if (lc < 84 && (lc % 9) != 4) begin
          pix_valid = 1'b1;
          luma = 8'((k * 29 + line * 13 + lc * 7 + salt) & 255);
          if (line == 0 && (col / w) == k)
            for (int p = 0; p < 4; p++)
              acc[p] = sign_neg(msel, p, k) ? acc[p] - 32'(luma) : acc[p] + 32'(luma);
          col++;
        end
      end
    end
    for (int p = 0; p < 4; p++) check_eq("R7 score held between strobes", score[p], last_sc[p]);
  endtask

  task automatic measure(input int sel, input int lg, input int fcm, input bit fs_ls,
                         input bit disturb);
    int fe = (fcm == 0) ? 1 : fcm;
    salt += 17;
    for (int k = 0; k < fe; k++) begin
      if (k == 0) begin
        walsh_sel   = 3'(sel);
        win_log     = 4'(lg);
        meas_frames = 8'(fcm);
        if (started) begin
          for (int p = 0; p < 4; p++) expv[p] = acc[p];
          pending = 1;
        end
        for (int p = 0; p < 4; p++) acc[p] = '0;
        started = 1;
      end
      if (k == 1 && disturb) begin  // R8: ignored until next measurement
        walsh_sel   = 3'(sel ^ 5);
        win_log     = 4'((lg ^ 1) & 15);
        meas_frames = 8'(fcm + 3);
      end
      do_frame(k, fs_ls ^ bit'(k % 2), sel, lg);  // R9 both alignments
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin acc[p] = '0; last_sc[p] = '0; expv[p] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 4; p++) check_eq("R1 reset score", score[p], 32'd0);
    check_eq("R1 reset done", 32'(done), 32'd0);
    for (int s = 0; s < 8; s++) measure(s, 0, 4, bit'(s % 2), 1'b0);  // R4 every group
    measure(5, 1, 3, 1'b0, 1'b1);  // R2 R8
    measure(2, 2, 2, 1'b1, 1'b0);
    measure(7, 3, 2, 1'b0, 1'b1);  // R2 window runs past line end
    measure(3, 0, 1, 1'b0, 1'b0);  // R5
    measure(6, 0, 0, 1'b1, 1'b0);  // R5 zero acts as one
    measure(1, 0, 9, 1'b0, 1'b1);  // R5 R3
    measure(4, 0, 4, 1'b1, 1'b0);  // flush previous
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule